// File: doc/BRIEF.md
# Reconvergence barrier warp regrouper

This block handles branch divergence in a SIMT core without a per-warp stack. When a warp splits at a branch, the warp is retired. Each non-empty side of the branch becomes a narrow warp of its own, with its own program counter and lane mask. Both go straight into a small issue pool, so the two paths can be scheduled independently.

In the same cycle the block reserves an entry in a set-associative barrier table. The entry is keyed by the reconvergence PC together with the parent warp id. It records which lanes must come back before the warp can be rebuilt. Arrival events name a key and carry the lanes that reached the reconvergence PC. The table collects those lanes. Once every expected lane has arrived, the entry is released and one rebuilt warp, covering the whole expected mask at the reconvergence PC, is committed to the issue pool.

The downstream pipeline takes warps from the head of the pool one at a time. If the barrier set a divergence needs is full, the divergence is held off with backpressure. The same happens when the pool is too full to accept the event's results.

Top module: `rbw_regroup`

## Requirements
- R1: After reset the issue pool is empty (`iss_valid` low), no barrier is live, and `div_ready` is high.
- R2: An accepted divergence (`div_valid` and `div_ready`) places the path-A warp and then the path-B warp into the pool. Each warp carries its own PC and mask, tag = parent id, and kind code 2'b00 (path A) or 2'b01 (path B). Both are visible from the cycle after acceptance.
- R3: A path whose lane mask is all zero is not placed into the pool.
- R4: An accepted divergence reserves one barrier keyed by (reconvergence PC, parent id). Its expected mask is the OR of the two path masks. It lives in set index (rpc XOR wid)[3:0], and a set holds 8 barriers.
- R5: An accepted arrival whose key matches a live barrier ORs into it those lanes of `arr_mask` that are in the expected mask. Other lanes are ignored. An arrival that matches no live barrier has no effect.
- R6: When an arrival makes the arrived mask equal to the expected mask, the barrier is freed. A rebuilt warp (pc = rpc, mask = expected, tag = parent id, kind 2'b10) enters the pool after any path warps pushed in the same cycle.
- R7: Two barriers with the same reconvergence PC but different parent ids are independent; arrivals for one never complete the other.
- R8: `div_ready` is low while the target set has all 8 ways occupied, or while the pool has fewer than 3 free slots. A held divergence changes nothing.
- R9: `arr_ready` is low while the pool is full. A held arrival changes nothing.
- R10: The pool holds 8 warps in arrival order. The head is presented on `iss_*` while `iss_valid` is high, and `iss_take` removes it.
- R11: A way freed by a completed barrier can be reserved again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_valid | input | 1 | Divergence event present |
| div_ready | output | 1 | Divergence event accepted this cycle |
| div_wid | input | 6 | Parent warp id of the divergence |
| div_rpc | input | 16 | Reconvergence PC |
| div_pc_a | input | 16 | PC of path A |
| div_mask_a | input | 8 | Lane mask of path A |
| div_pc_b | input | 16 | PC of path B |
| div_mask_b | input | 8 | Lane mask of path B |
| arr_valid | input | 1 | Arrival event present |
| arr_ready | output | 1 | Arrival event accepted this cycle |
| arr_wid | input | 6 | Parent warp id of the barrier reached |
| arr_rpc | input | 16 | Reconvergence PC reached |
| arr_mask | input | 8 | Lanes arriving |
| iss_valid | output | 1 | Pool head holds a warp |
| iss_take | input | 1 | Remove the pool head |
| iss_pc | output | 16 | PC of the head warp |
| iss_mask | output | 8 | Lane mask of the head warp |
| iss_wid | output | 6 | Parent id tag of the head warp |
| iss_kind | output | 2 | 00 path A, 01 path B, 10 rebuilt |

## Verification
A barrier that keeps stale arrived lanes, or that matches the wrong key, shows at the ports one cycle after the deciding arrival. The rebuilt warp is then either missing or early at the pool head, or it carries the wrong mask or tag. Wrong way occupancy shows directly in `div_ready`, in the same cycle the event is presented. A pool pointer or count error shows at the next head change, as a warp in the wrong order or as a wrong `iss_valid`. The bench keeps its own model of the barriers and the pool and compares the handshakes and the pool head every cycle.

// File: rtl/rbw_pkg.sv
// Shared definitions for the warp regrouper.
package rbw_pkg;
    // Kind of warp placed into the issue pool.
    typedef enum logic [1:0] {
        KIND_PATH_A = 2'b00,
        KIND_PATH_B = 2'b01,
        KIND_REJOIN = 2'b10
    } warp_kind_e;
endpackage

// File: rtl/rbw_way_pick.sv
// Lowest-index picker over a request vector.
// Assumes: N >= 1. found is low when no bit is set, and idx is then zero.
module rbw_way_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rbw_barrier_table.sv
// Set-associative table of reconvergence barriers.
// Each entry holds a key (rpc, parent id), an expected lane mask and an
// arrived lane mask. An insert takes the lowest free way of its set. An
// arrival merges lanes into the matching entry and reports completion in
// the same cycle. Completion releases the way at the clock edge.
// Assumes: ins_en only when ins_room; keys are unique among live entries.
module rbw_barrier_table #(
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int WID_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [SET_W-1:0] ins_set,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [WID_W-1:0] ins_wid,
    input  logic [LANES-1:0] ins_exp,
    output logic             ins_room,
    input  logic             arr_en,
    input  logic [SET_W-1:0] arr_set,
    input  logic [PC_W-1:0]  arr_pc,
    input  logic [WID_W-1:0] arr_wid,
    input  logic [LANES-1:0] arr_mask,
    output logic             done,
    output logic [PC_W-1:0]  done_pc,
    output logic [WID_W-1:0] done_wid,
    output logic [LANES-1:0] done_mask
);
    logic [WAYS-1:0]  vld  [SETS];
    logic [PC_W-1:0]  tpc  [SETS][WAYS];
    logic [WID_W-1:0] twid [SETS][WAYS];
    logic [LANES-1:0] texp [SETS][WAYS];
    logic [LANES-1:0] tarr [SETS][WAYS];

    logic [WAYS-1:0]  free_vec;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] ins_way;
    logic [WAY_W-1:0] hit_way;
    logic             hit;
    logic [LANES-1:0] cur_exp;
    logic [LANES-1:0] merged;

    // Free ways of the insert set.
    assign free_vec = ~vld[ins_set];

    rbw_way_pick #(.N(WAYS)) u_free (
        .req   (free_vec),
        .found (ins_room),
        .idx   (ins_way)
    );

    // One key comparator per way of the arrival set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[arr_set][w]
                            && (tpc[arr_set][w] == arr_pc)
                            && (twid[arr_set][w] == arr_wid);
    end

    rbw_way_pick #(.N(WAYS)) u_hit (
        .req   (hit_vec),
        .found (hit),
        .idx   (hit_way)
    );

    // Merge the arriving lanes and test the entry for completion.
    always_comb begin
        cur_exp   = texp[arr_set][hit_way];
        merged    = tarr[arr_set][hit_way] | (arr_mask & cur_exp);
        done      = arr_en && hit && (merged == cur_exp);
        done_pc   = arr_pc;
        done_wid  = arr_wid;
        done_mask = cur_exp;
    end

    // Valid bits: clear on completion, set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else begin
            if (done) vld[arr_set][hit_way] <= 1'b0;
            if (ins_en) vld[ins_set][ins_way] <= 1'b1;
        end
    end

    // Entry payload: key and masks, written on insert or merge.
    always_ff @(posedge clk) begin
        if (arr_en && hit) tarr[arr_set][hit_way] <= merged;
        if (ins_en) begin
            tpc[ins_set][ins_way]  <= ins_pc;
            twid[ins_set][ins_way] <= ins_wid;
            texp[ins_set][ins_way] <= ins_exp;
            tarr[ins_set][ins_way] <= '0;
        end
    end
endmodule

// File: rtl/rbw_issue_pool.sv
// In-order pool of ready warps with several pushes per cycle.
// Valid pushes are packed behind the tail in index order. The head is
// presented combinationally and pop removes it.
// Assumes: DEPTH is a power of two; the caller never pushes more than
// free_cnt entries in one cycle.
module rbw_issue_pool #(
    parameter int DEPTH = 8,
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int WID_W = 6,
    parameter int NPUSH = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPUSH-1:0] push_v,
    input  logic [PC_W-1:0]  push_pc   [NPUSH],
    input  logic [LANES-1:0] push_mask [NPUSH],
    input  logic [WID_W-1:0] push_wid  [NPUSH],
    input  logic [1:0]       push_kind [NPUSH],
    input  logic             pop,
    output logic             out_valid,
    output logic [PC_W-1:0]  out_pc,
    output logic [LANES-1:0] out_mask,
    output logic [WID_W-1:0] out_wid,
    output logic [1:0]       out_kind,
    output logic [CNT_W-1:0] free_cnt
);
    logic [PC_W-1:0]  mem_pc   [DEPTH];
    logic [LANES-1:0] mem_mask [DEPTH];
    logic [WID_W-1:0] mem_wid  [DEPTH];
    logic [1:0]       mem_kind [DEPTH];

    logic [PTR_W-1:0] head;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] slot [NPUSH];
    logic [CNT_W-1:0] npush;
    logic             do_pop;

    // Slot for each push: tail plus the number of valid pushes before it.
    always_comb begin
        logic [PTR_W-1:0] acc;
        acc = head + PTR_W'(cnt);
        for (int i = 0; i < NPUSH; i++) begin
            slot[i] = acc;
            if (push_v[i]) acc = acc + 1'b1;
        end
        npush  = CNT_W'($countones(push_v));
        do_pop = pop && (cnt != '0);
    end

    // Head and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (do_pop) head <= head + 1'b1;
            cnt <= cnt + npush - CNT_W'(do_pop);
        end
    end

    // Storage writes for the packed pushes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPUSH; i++) begin
            if (push_v[i]) begin
                mem_pc[slot[i]]   <= push_pc[i];
                mem_mask[slot[i]] <= push_mask[i];
                mem_wid[slot[i]]  <= push_wid[i];
                mem_kind[slot[i]] <= push_kind[i];
            end
        end
    end

    // Head presentation and free space.
    always_comb begin
        out_valid = (cnt != '0);
        out_pc    = mem_pc[head];
        out_mask  = mem_mask[head];
        out_wid   = mem_wid[head];
        out_kind  = mem_kind[head];
        free_cnt  = CNT_W'(DEPTH) - cnt;
    end
endmodule

// File: rtl/rbw_regroup.sv
// Divergence regrouper top level.
// A divergence spawns up to two path warps into the issue pool and reserves
// a barrier. Arrivals fill the barrier, and a full barrier is rebuilt into
// one warp at the reconvergence PC. Pool push order: path A, path B, rebuilt.
// Assumes: the caller never presents a divergence whose key is already live.
module rbw_regroup
    import rbw_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int WID_W = 6,
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int POOL  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_valid,
    output logic             div_ready,
    input  logic [WID_W-1:0] div_wid,
    input  logic [PC_W-1:0]  div_rpc,
    input  logic [PC_W-1:0]  div_pc_a,
    input  logic [LANES-1:0] div_mask_a,
    input  logic [PC_W-1:0]  div_pc_b,
    input  logic [LANES-1:0] div_mask_b,
    input  logic             arr_valid,
    output logic             arr_ready,
    input  logic [WID_W-1:0] arr_wid,
    input  logic [PC_W-1:0]  arr_rpc,
    input  logic [LANES-1:0] arr_mask,
    output logic             iss_valid,
    input  logic             iss_take,
    output logic [PC_W-1:0]  iss_pc,
    output logic [LANES-1:0] iss_mask,
    output logic [WID_W-1:0] iss_wid,
    output logic [1:0]       iss_kind
);
    localparam int SET_W  = $clog2(SETS);
    localparam int FREE_W = $clog2(POOL + 1);
    localparam int NPUSH  = 3;

    logic [SET_W-1:0]  div_set;
    logic [SET_W-1:0]  arr_set;
    logic              set_room;
    logic              div_fire;
    logic              arr_fire;
    logic [FREE_W-1:0] pool_free;
    logic              bt_done;
    logic [PC_W-1:0]   bt_pc;
    logic [WID_W-1:0]  bt_wid;
    logic [LANES-1:0]  bt_mask;

    logic [NPUSH-1:0]  push_v;
    logic [PC_W-1:0]   push_pc   [NPUSH];
    logic [LANES-1:0]  push_mask [NPUSH];
    logic [WID_W-1:0]  push_wid  [NPUSH];
    logic [1:0]        push_kind [NPUSH];

    // Set index: low bits of (rpc XOR parent id) for both event kinds.
    always_comb begin
        for (int b = 0; b < SET_W; b++) begin
            div_set[b] = ((b < PC_W) ? div_rpc[b % PC_W] : 1'b0)
                       ^ ((b < WID_W) ? div_wid[b % WID_W] : 1'b0);
            arr_set[b] = ((b < PC_W) ? arr_rpc[b % PC_W] : 1'b0)
                       ^ ((b < WID_W) ? arr_wid[b % WID_W] : 1'b0);
        end
    end

    // Acceptance: a divergence may push three warps in the worst case.
    always_comb begin
        div_ready = set_room && (pool_free >= FREE_W'(NPUSH));
        arr_ready = (pool_free != '0);
        div_fire  = div_valid && div_ready;
        arr_fire  = arr_valid && arr_ready;
    end

    rbw_barrier_table #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .LANES (LANES),
        .PC_W  (PC_W),
        .WID_W (WID_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (div_fire),
        .ins_set   (div_set),
        .ins_pc    (div_rpc),
        .ins_wid   (div_wid),
        .ins_exp   (div_mask_a | div_mask_b),
        .ins_room  (set_room),
        .arr_en    (arr_fire),
        .arr_set   (arr_set),
        .arr_pc    (arr_rpc),
        .arr_wid   (arr_wid),
        .arr_mask  (arr_mask),
        .done      (bt_done),
        .done_pc   (bt_pc),
        .done_wid  (bt_wid),
        .done_mask (bt_mask)
    );

    // Pool pushes in fixed order: path A, path B, rebuilt warp.
    always_comb begin
        push_v[0]    = div_fire && (div_mask_a != '0);
        push_pc[0]   = div_pc_a;
        push_mask[0] = div_mask_a;
        push_wid[0]  = div_wid;
        push_kind[0] = KIND_PATH_A;
        push_v[1]    = div_fire && (div_mask_b != '0);
        push_pc[1]   = div_pc_b;
        push_mask[1] = div_mask_b;
        push_wid[1]  = div_wid;
        push_kind[1] = KIND_PATH_B;
        push_v[2]    = bt_done;
        push_pc[2]   = bt_pc;
        push_mask[2] = bt_mask;
        push_wid[2]  = bt_wid;
        push_kind[2] = KIND_REJOIN;
    end

    rbw_issue_pool #(
        .DEPTH (POOL),
        .LANES (LANES),
        .PC_W  (PC_W),
        .WID_W (WID_W),
        .NPUSH (NPUSH)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_v    (push_v),
        .push_pc   (push_pc),
        .push_mask (push_mask),
        .push_wid  (push_wid),
        .push_kind (push_kind),
        .pop       (iss_take),
        .out_valid (iss_valid),
        .out_pc    (iss_pc),
        .out_mask  (iss_mask),
        .out_wid   (iss_wid),
        .out_kind  (iss_kind),
        .free_cnt  (pool_free)
    );
endmodule

// File: rtl/rbw_regroup_chk.sv
// Property checker for the regrouper, attached to every instance by bind.
// Observes the handshakes, the pool free count and barrier completion.
module rbw_regroup_chk #(
    parameter int LANES  = 8,
    parameter int POOL   = 8,
    parameter int FREE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_valid,
    input logic              div_ready,
    input logic [LANES-1:0]  div_mask_a,
    input logic [LANES-1:0]  div_mask_b,
    input logic              arr_ready,
    input logic              iss_valid,
    input logic              iss_take,
    input logic [FREE_W-1:0] pool_free,
    input logic              bt_done
);
    // R10: free space never exceeds the pool depth.
    a_r10_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pool_free) <= POOL);

    // R9: a full pool blocks arrivals.
    a_r9_full_blocks_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_free == '0) |-> !arr_ready);

    // R8: too little pool space blocks divergences.
    a_r8_short_pool_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pool_free) < 3) |-> !div_ready);

    // R2: a two-sided split without a pop takes at least two slots.
    a_r2_split_takes_two: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && div_ready && (div_mask_a != '0) && (div_mask_b != '0)
         && !(iss_valid && iss_take))
        |=> (int'(pool_free) + 2 <= int'($past(pool_free))));

    // R6: a completed barrier without a pop takes a slot.
    a_r6_rejoin_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (bt_done && !(iss_valid && iss_take))
        |=> (int'(pool_free) < int'($past(pool_free))));

    // R10: a lone pop frees exactly one slot.
    a_r10_pop_frees_one: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_take && !(div_valid && div_ready) && !bt_done)
        |=> (int'(pool_free) == int'($past(pool_free)) + 1));
endmodule

bind rbw_regroup rbw_regroup_chk #(
    .LANES  (LANES),
    .POOL   (POOL),
    .FREE_W (FREE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_valid  (div_valid),
    .div_ready  (div_ready),
    .div_mask_a (div_mask_a),
    .div_mask_b (div_mask_b),
    .arr_ready  (arr_ready),
    .iss_valid  (iss_valid),
    .iss_take   (iss_take),
    .pool_free  (pool_free),
    .bt_done    (bt_done)
);

// File: tb/tb_rbw_regroup.sv
// Bench for the regrouper: a behavioural model of barriers and pool,
// compared with the design on every clock, plus directed corner cases.
module tb_rbw_regroup;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 8;
    localparam int POOL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_valid = 1'b0;
    logic        div_ready;
    logic [5:0]  div_wid = '0;
    logic [15:0] div_rpc = '0;
    logic [15:0] div_pc_a = '0;
    logic [7:0]  div_mask_a = '0;
    logic [15:0] div_pc_b = '0;
    logic [7:0]  div_mask_b = '0;
    logic        arr_valid = 1'b0;
    logic        arr_ready;
    logic [5:0]  arr_wid = '0;
    logic [15:0] arr_rpc = '0;
    logic [7:0]  arr_mask = '0;
    logic        iss_valid;
    logic        iss_take = 1'b0;
    logic [15:0] iss_pc;
    logic [7:0]  iss_mask;
    logic [5:0]  iss_wid;
    logic [1:0]  iss_kind;

    rbw_regroup dut (
        .clk(clk), .rst_n(rst_n),
        .div_valid(div_valid), .div_ready(div_ready), .div_wid(div_wid),
        .div_rpc(div_rpc), .div_pc_a(div_pc_a), .div_mask_a(div_mask_a),
        .div_pc_b(div_pc_b), .div_mask_b(div_mask_b),
        .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_wid(arr_wid),
        .arr_rpc(arr_rpc), .arr_mask(arr_mask),
        .iss_valid(iss_valid), .iss_take(iss_take), .iss_pc(iss_pc),
        .iss_mask(iss_mask), .iss_wid(iss_wid), .iss_kind(iss_kind)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {int pc; int mask; int wid; int kind;} mw_t;
    mw_t q[$];
    int bexp[int];
    int barr[int];
    int n_chk = 0;
    int n_fail = 0;

    function automatic int set_of(int rpc, int wid);
        return (rpc ^ wid) & 15;
    endfunction

    function automatic int key_of(int rpc, int wid);
        return rpc * 64 + wid;
    endfunction

    function automatic int set_count(int s);
        int c = 0;
        foreach (bexp[k]) if (set_of(k / 64, k % 64) == s) c++;
        return c;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the pool head with the model (R10, R2, R6).
    task automatic compare_head();
        chk(iss_valid == (q.size() > 0), "R10", "iss_valid", int'(iss_valid), int'(q.size() > 0));
        if (iss_valid && q.size() > 0) begin
            string r = (q[0].kind == 2) ? "R6" : "R2";
            chk(int'(iss_pc) == q[0].pc, r, "iss_pc", int'(iss_pc), q[0].pc);
            chk(int'(iss_mask) == q[0].mask, r, "iss_mask", int'(iss_mask), q[0].mask);
            chk(int'(iss_wid) == q[0].wid, r, "iss_wid", int'(iss_wid), q[0].wid);
            chk(int'(iss_kind) == q[0].kind, r, "iss_kind", int'(iss_kind), q[0].kind);
        end
    endtask

    // One clock: check handshakes, advance the model, check the head.
    task automatic cycle();
        bit mdiv, marr, rej;
        int dk, ak, rpc_s, wid_s, rmask;
        #1;
        mdiv = (set_count(set_of(int'(div_rpc), int'(div_wid))) < WAYS) && (POOL - q.size() >= 3);
        marr = (POOL - q.size() >= 1);
        chk(div_ready == mdiv, "R8", "div_ready", int'(div_ready), int'(mdiv));
        chk(arr_ready == marr, "R9", "arr_ready", int'(arr_ready), int'(marr));
        @(posedge clk);
        rej = 1'b0;
        if (iss_take && q.size() > 0) void'(q.pop_front());
        if (arr_valid && marr) begin
            ak = key_of(int'(arr_rpc), int'(arr_wid));
            if (bexp.exists(ak)) begin
                barr[ak] = barr[ak] | (int'(arr_mask) & bexp[ak]);
                if (barr[ak] == bexp[ak]) begin
                    rej = 1'b1; rpc_s = int'(arr_rpc); wid_s = int'(arr_wid); rmask = bexp[ak];
                    bexp.delete(ak); barr.delete(ak);
                end
            end
        end
        if (div_valid && mdiv) begin
            dk = key_of(int'(div_rpc), int'(div_wid));
            if (div_mask_a != 0) q.push_back('{int'(div_pc_a), int'(div_mask_a), int'(div_wid), 0});
            if (div_mask_b != 0) q.push_back('{int'(div_pc_b), int'(div_mask_b), int'(div_wid), 1});
            bexp[dk] = int'(div_mask_a | div_mask_b);
            barr[dk] = 0;
        end
        if (rej) q.push_back('{rpc_s, rmask, wid_s, 2});
        @(negedge clk);
        compare_head();
    endtask

    task automatic idle();
        div_valid = 1'b0;
        arr_valid = 1'b0;
    endtask

    task automatic drv_div(int w, int rpc, int pa, int ma, int pb, int mb);
        div_valid = 1'b1; div_wid = 6'(w); div_rpc = 16'(rpc);
        div_pc_a = 16'(pa); div_mask_a = 8'(ma); div_pc_b = 16'(pb); div_mask_b = 8'(mb);
    endtask

    task automatic drv_arr(int w, int rpc, int m);
        arr_valid = 1'b1; arr_wid = 6'(w); arr_rpc = 16'(rpc); arr_mask = 8'(m);
    endtask

    task automatic drain();
        idle();
        iss_take = 1'b1;
        repeat (10) cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(iss_valid == 1'b0, "R1", "iss_valid after reset", int'(iss_valid), 0);
        chk(div_ready == 1'b1, "R1", "div_ready after reset", int'(div_ready), 1);
        @(negedge clk);

        // R2: split and in-order presentation.
        drv_div(1, 'h40, 'h10, 'h0F, 'h20, 'hF0);
        cycle(); idle(); cycle();
        chk(iss_valid && iss_pc == 'h10 && iss_kind == 2'b00, "R2", "path A at head", int'(iss_pc), 'h10);
        iss_take = 1'b1; cycle();
        chk(iss_valid && iss_pc == 'h20 && iss_kind == 2'b01, "R2", "path B at head", int'(iss_pc), 'h20);
        cycle();

        // R5: partial arrival, then a miss on another parent id.
        drv_arr(1, 'h40, 'h0F); cycle(); idle(); cycle();
        chk(!iss_valid, "R5", "partial arrival no rejoin", int'(iss_valid), 0);
        drv_arr(3, 'h40, 'hFF); cycle(); idle(); cycle();
        chk(!iss_valid, "R5", "unmatched arrival ignored", int'(iss_valid), 0);
        drv_arr(1, 'h40, 'hF0); cycle(); idle();
        chk(iss_valid && iss_mask == 'hFF && iss_kind == 2'b10 && iss_pc == 'h40, "R6", "rejoin warp", int'(iss_mask), 'hFF);
        drain();

        // R5: lanes outside the expected mask are ignored.
        drv_div(5, 'h50, 'h11, 'h03, 'h12, 'h0C); cycle(); drain();
        drv_arr(5, 'h50, 'hF3); cycle(); idle(); cycle();
        chk(!iss_valid, "R5", "outside lanes ignored", int'(iss_valid), 0);
        drv_arr(5, 'h50, 'h0C); cycle(); idle();
        chk(iss_valid && iss_mask == 'h0F, "R5", "rejoin mask limited to expected", int'(iss_mask), 'h0F);
        drain();

        // R3: empty path is not spawned.
        iss_take = 1'b0;
        drv_div(4, 'h80, 'h30, 'h55, 'h31, 'h00); cycle(); idle(); cycle();
        chk(iss_valid && iss_pc == 'h30, "R3", "single path at head", int'(iss_pc), 'h30);
        iss_take = 1'b1; cycle();
        chk(!iss_valid, "R3", "no empty path warp", int'(iss_valid), 0);
        drv_arr(4, 'h80, 'h55); cycle(); drain();

        // R7: same reconvergence PC, different parents.
        drv_div(1, 'h90, 'h60, 'h01, 'h61, 'h02); cycle();
        drv_div(2, 'h90, 'h62, 'h04, 'h63, 'h08); cycle(); drain();
        drv_arr(2, 'h90, 'h0C); cycle(); idle();
        chk(iss_valid && iss_wid == 2 && iss_mask == 'h0C, "R7", "rejoin for parent 2", int'(iss_wid), 2);
        drain();
        drv_arr(1, 'h90, 'h0C); cycle(); idle(); cycle();
        chk(!iss_valid, "R7", "parent 1 not completed by other lanes", int'(iss_valid), 0);
        drv_arr(1, 'h90, 'h03); cycle(); idle();
        chk(iss_valid && iss_wid == 1, "R7", "rejoin for parent 1", int'(iss_wid), 1);
        drain();

        // R4/R8/R11: fill set 5, hold a ninth divergence, free a way.
        for (int w = 16; w < 24; w++) begin
            drv_div(w, ((w ^ 5) & 15) | 'h200, 'h70, 'h01, 'h71, 'h02); cycle(); drain();
        end
        drv_div(30, ((30 ^ 5) & 15) | 'h200, 'h72, 'h01, 'h73, 'h02);
        #1;
        chk(!div_ready, "R8", "full set blocks divergence", int'(div_ready), 0);
        cycle();
        chk(!iss_valid, "R8", "held divergence has no effect", int'(iss_valid), 0);
        drv_arr(16, ((16 ^ 5) & 15) | 'h200, 'h03); cycle(); arr_valid = 1'b0;
        #1;
        chk(div_ready, "R11", "freed way accepts divergence", int'(div_ready), 1);
        cycle(); drain();

        // R9: fill the pool, then hold an arrival.
        iss_take = 1'b0;
        drv_div(40, 'h300, 'h80, 'h01, 'h81, 'h02); cycle();
        drv_div(41, 'h301, 'h82, 'h01, 'h83, 'h02); cycle();
        drv_div(42, 'h302, 'h84, 'h01, 'h85, 'h02); cycle(); idle();
        drv_arr(40, 'h300, 'h03); cycle();
        drv_arr(41, 'h301, 'h03); cycle();
        drv_arr(42, 'h302, 'h03);
        #1;
        chk(!arr_ready, "R9", "full pool blocks arrival", int'(arr_ready), 0);
        chk(!div_ready, "R8", "full pool blocks divergence", int'(div_ready), 0);
        cycle(); cycle();
        drain();
        drv_arr(42, 'h302, 'h01); cycle(); idle(); cycle();
        chk(!iss_valid, "R9", "held arrival had no effect", int'(iss_valid), 0);
        drv_arr(42, 'h302, 'h02); cycle(); drain();

        // Mixed traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            int w, rpc;
            idle();
            iss_take = ($urandom_range(9) < 7);
            if ($urandom_range(9) < 3) begin
                w = $urandom_range(63);
                rpc = $urandom_range(63);
                if (!bexp.exists(key_of(rpc, w)))
                    drv_div(w, rpc, $urandom_range(16'hFFFF), $urandom_range(255),
                            $urandom_range(16'hFFFF), $urandom_range(255));
            end
            if ($urandom_range(9) < 4) begin
                int ks[$];
                foreach (bexp[k]) ks.push_back(k);
                if (ks.size() > 0 && $urandom_range(9) < 8) begin
                    int k = ks[$urandom_range(ks.size() - 1)];
                    drv_arr(k % 64, k / 64, $urandom_range(255));
                end else begin
                    drv_arr($urandom_range(63), $urandom_range(63), $urandom_range(255));
                end
            end
            cycle();
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule